// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A 32-pin general-purpose I/O port attached to a simple 32-bit register bus. Software sets an output value and a per-pin drive enable. It reads back the input pads after they are synchronized to the port clock. Each pin can raise an interrupt on a low level, a high level, a rising edge or a falling edge. A per-pin override makes a pin sensitive to both edges.

Detected events collect in a sticky status register. Software clears a status bit by writing one to it. A mask register gates the status bits onto two interrupt lines: one serves the lower sixteen pins and the other the upper sixteen. The bus has no wait states. A write takes effect at the clock edge where `wr_en` is high. Read data is a combinational function of `addr` and the current register contents.

Top module: `gpio_irq_port`

## Requirements
- R1: The register offsets are: 0x00 output data, 0x04 direction, 0x08 synchronized pad value (read-only), 0x0C trigger fields for pins 0-15, 0x10 trigger fields for pins 16-31, 0x14 mask, 0x18 status, 0x1C both-edge select. Any other offset reads as zero, and a write to it changes nothing. A write to 0x08 also changes nothing.
- R2: `pad_out` equals the data register and `pad_oe` equals the direction register, where 1 means drive. Reading 0x00 or 0x04 returns the value last written.
- R3: Offset 0x08 returns `pad_in` after a two-flop synchronizer. A pad value held across clock edge k is readable after edge k+1.
- R4: Pin n uses the 2-bit field at bits [2*(n mod 16)+1 : 2*(n mod 16)] of 0x0C (pins 0-15) or of 0x10 (pins 16-31). Code 00 selects low level and 01 selects high level. A level trigger sets the status bit on every cycle while the synchronized pad holds that level.
- R5: Code 10 selects rising edge and 11 selects falling edge. An edge is seen when the synchronized pad differs from its value one cycle earlier. A pad change sampled at edge k sets the status bit at edge k+2.
- R6: When a pin's bit in 0x1C is 1, the pin sets status on both rising and falling edges, and its trigger field has no effect.
- R7: Status bits are sticky. Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged.
- R8: `irq_lo` is the OR over pins 0-15 of (status AND mask), and `irq_hi` is the same over pins 16-31. A mask bit of 1 enables the pin.
- R9: After reset, all registers read as zero (data, direction, trigger fields, mask, status and edge select), and both interrupt lines are low.
- R10: If detection and a software clear hit the same status bit in the same cycle, the bit ends up set. As a result, a level-triggered bit reappears right after it is cleared while the level persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pad_in | input | 32 | Asynchronous pad input values |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt for pins 0-15 |
| irq_hi | output | 1 | Interrupt for pins 16-31 |

## Verification
A software clear of a status bit and a hardware detection on that same bit can land on the same clock edge. The bench provokes this in two ways. First, it holds pins in level-trigger mode while writing all-ones to the status register. Second, it changes pads exactly two cycles before a clear lands, so that an edge detection and the clear coincide. A cycle-accurate behavioural model in the bench decides that the set wins. Status readback and both interrupt lines are compared against that model on every clock, so a design that lets the clear win shows up on the next cycle.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_oe,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam int unsigned HALF = DW / 2;
  localparam logic [AW-1:0] A_DATA = AW'(8'h00);
  localparam logic [AW-1:0] A_DIR  = AW'(8'h04);
  localparam logic [AW-1:0] A_PAD  = AW'(8'h08);
  localparam logic [AW-1:0] A_TRLO = AW'(8'h0C);
  localparam logic [AW-1:0] A_TRHI = AW'(8'h10);
  localparam logic [AW-1:0] A_MASK = AW'(8'h14);
  localparam logic [AW-1:0] A_STAT = AW'(8'h18);
  localparam logic [AW-1:0] A_BOTH = AW'(8'h1C);

  logic [DW-1:0] data_q, dir_q, trlo_q, trhi_q, mask_q, stat_q, both_q;
  logic [DW-1:0] meta_q, sync_q, hist_q;
  logic [DW-1:0] hit, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_pin
    localparam int unsigned F = 2 * (i % HALF);
    logic [1:0] mode;
    assign mode = (i < HALF) ? trlo_q[F+1:F] : trhi_q[F+1:F];
    always_comb begin
      if (both_q[i]) hit[i] = sync_q[i] ^ hist_q[i];
      else begin
        case (mode)
          2'b00:   hit[i] = ~sync_q[i];
          2'b01:   hit[i] = sync_q[i];
          2'b10:   hit[i] = sync_q[i] & ~hist_q[i];
          default: hit[i] = ~sync_q[i] & hist_q[i];
        endcase
      end
    end
  end

  assign clr = (wr_en && addr == A_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      trlo_q <= '0;
      trhi_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
      both_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | hit;
      if (wr_en) begin
        case (addr)
          A_DATA: data_q <= wdata;
          A_DIR:  dir_q  <= wdata;
          A_TRLO: trlo_q <= wdata;
          A_TRHI: trhi_q <= wdata;
          A_MASK: mask_q <= wdata;
          A_BOTH: both_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = data_q;
      A_DIR:   rdata = dir_q;
      A_PAD:   rdata = sync_q;
      A_TRLO:  rdata = trlo_q;
      A_TRHI:  rdata = trhi_q;
      A_MASK:  rdata = mask_q;
      A_STAT:  rdata = stat_q;
      A_BOTH:  rdata = both_q;
      default: rdata = '0;
    endcase
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq_lo  = |(stat_q[HALF-1:0] & mask_q[HALF-1:0]);
  assign irq_hi  = |(stat_q[DW-1:HALF] & mask_q[DW-1:HALF]);

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R7
  AST_CLEAR_WRITTEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT) |=> ((~stat_q & $past(stat_q) & ~$past(wdata)) == '0)); // R7
  AST_BOTH_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((both_q & (sync_q ^ hist_q)) != '0) |=>
      ((stat_q & $past(both_q & (sync_q ^ hist_q))) == $past(both_q & (sync_q ^ hist_q)))); // R6
  AST_LEVEL_HIGH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!both_q[0] && trlo_q[1:0] == 2'b01 && sync_q[0]) |=> stat_q[0]); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!irq_lo && !irq_hi)); // R8
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic irq_lo, irq_hi;

  int errors = 0;
  int checks = 0;
  int rot = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  logic [31:0] m_data, m_dir, m_lo, m_hi, m_mask, m_stat, m_both;
  logic [31:0] pq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = '0; m_dir = '0; m_lo = '0; m_hi = '0;
      m_mask = '0; m_stat = '0; m_both = '0;
      pq = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] now, old, det, clr;
      now = pq[1];
      old = pq[2];
      for (int i = 0; i < 32; i++) begin
        int code;
        code = (i < 16) ? int'((m_lo >> (2*i)) & 3) : int'((m_hi >> (2*(i-16))) & 3);
        if (m_both[i]) det[i] = now[i] != old[i];
        else if (code == 0) det[i] = !now[i];
        else if (code == 1) det[i] = now[i];
        else if (code == 2) det[i] = now[i] && !old[i];
        else det[i] = !now[i] && old[i];
      end
      clr = (wr_en && addr == 8'h18) ? wdata : 32'h0;
      m_stat = (m_stat & ~clr) | det;
      if (wr_en) begin
        if (addr == 8'h00) m_data = wdata;
        if (addr == 8'h04) m_dir = wdata;
        if (addr == 8'h0C) m_lo = wdata;
        if (addr == 8'h10) m_hi = wdata;
        if (addr == 8'h14) m_mask = wdata;
        if (addr == 8'h1C) m_both = wdata;
      end
      pq.push_front(pad_in);
      void'(pq.pop_back());
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return m_data;
      8'h04: return m_dir;
      8'h08: return pq[1];
      8'h0C: return m_lo;
      8'h10: return m_hi;
      8'h14: return m_mask;
      8'h18: return m_stat;
      8'h1C: return m_both;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R2";
      8'h08: return "R3";
      8'h0C, 8'h10: return "R4";
      8'h14: return "R8";
      8'h18: return "R7";
      8'h1C: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done && pq.size() == 3) begin
      chk(tag_of(addr), rdata, exp_rd(addr));
      chk("R8", {31'h0, irq_lo}, {31'h0, |(m_stat[15:0] & m_mask[15:0])});
      chk("R8", {31'h0, irq_hi}, {31'h0, |(m_stat[31:16] & m_mask[31:16])});
      chk("R2", pad_out, m_data);
      chk("R2", pad_oe, m_dir);
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      wr_en = 1'b0;
      addr = (rot == 8) ? 8'h24 : 8'(rot * 4);
      rot = (rot + 1) % 9;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic peek(logic [7:0] a);
    @(negedge clk); #1;
    wr_en = 1'b0; addr = a;
    @(negedge clk);
  endtask

  task automatic pads(logic [31:0] v);
    @(negedge clk); #1;
    wr_en = 1'b0; pad_in = v;
  endtask

  task automatic summary;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    addr = 8'h18; #1; chk("R9", rdata, 32'h0);
    addr = 8'h14; #1; chk("R9", rdata, 32'h0);
    chk("R9", {30'h0, irq_hi, irq_lo}, 32'h0);
    @(negedge clk); #1; rst_n = 1'b1;
    idle(3);
    // R2 data and direction
    wr(8'h00, 32'hA5A5_0F0F);
    wr(8'h04, 32'hFFFF_0000);
    peek(8'h00); chk("R2", rdata, 32'hA5A5_0F0F);
    // R1 ignored writes
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h24, 32'h1234_5678);
    peek(8'h24); chk("R1", rdata, 32'h0);
    // R4/R5 rising everywhere, clear level leftovers
    wr(8'h0C, 32'hAAAA_AAAA);
    wr(8'h10, 32'hAAAA_AAAA);
    wr(8'h18, 32'hFFFF_FFFF);
    idle(3);
    wr(8'h18, 32'hFFFF_FFFF);
    peek(8'h18); chk("R7", rdata, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    pads(32'h0000_0001);
    idle(1);
    peek(8'h08); chk("R3", rdata, 32'h0000_0001);
    idle(2);
    peek(8'h18); chk("R5", rdata, 32'h0000_0001);
    pads(32'h0001_0000);
    idle(4);
    chk("R8", {31'h0, irq_hi}, 32'h1);
    wr(8'h18, 32'h0000_0000);
    peek(8'h18); chk("R7", rdata, 32'h0001_0001);
    wr(8'h18, 32'h0000_0001);
    peek(8'h18); chk("R7", rdata, 32'h0001_0000);
    // R4 mixed modes
    wr(8'h0C, 32'hE4E4_E4E4);
    wr(8'h10, 32'h1B1B_1B1B);
    for (int p = 0; p < 5; p++) begin
      logic [31:0] pat [5] = '{32'hFFFF_FFFF, 32'h0, 32'h5555_AAAA, 32'hF0F0_0F0F, 32'h0};
      pads(pat[p]);
      idle(4);
      wr(8'h18, 32'hFFFF_FFFF);
      idle(2);
    end
    // R6 both-edge override with mode fields saying rising
    wr(8'h0C, 32'hAAAA_AAAA);
    wr(8'h10, 32'hAAAA_AAAA);
    wr(8'h1C, 32'h8000_F00F);
    idle(3);
    wr(8'h18, 32'hFFFF_FFFF);
    pads(32'hFFFF_FFFF);
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);
    pads(32'h0);
    idle(4);
    peek(8'h18); chk("R6", rdata, 32'h8000_F00F);
    // R10 set beats clear: clear lands together with an edge hit
    wr(8'h1C, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    pads(32'h0000_00F0);
    idle(1);
    wr(8'h18, 32'hFFFF_FFFF);
    peek(8'h18); chk("R10", rdata, 32'h0000_00F0);
    // R10 level low re-asserts after clear
    wr(8'h0C, 32'h0);
    idle(3);
    wr(8'h18, 32'hFFFF_FFFF);
    peek(8'h18); chk("R10", rdata & 32'h0000_FF0F, 32'h0000_FF0F);
    wr(8'h14, 32'h0);
    idle(2);
    chk("R8", {30'h0, irq_hi, irq_lo}, 32'h0);
    idle(5);
    summary();
  end
endmodule